// File: doc/BRIEF.md
# Multi-Channel Down-Counting Interval Timer

This block holds several independent timer channels, six by default. Software loads a start count into a channel and picks a tick source and a divisor. The channel then counts down by one on each divided tick. When a tick arrives while the count is already zero, the channel has expired. It raises its pending flag in a shared status register. It then either reloads from its interval register or stops at zero, as its control bits direct.

Software reaches the block through a plain 32-bit register port: address, write strobe, write data, and a combinational read-data bus. A single interrupt line is the OR, over all channels, of each pending flag gated by its enable bit.

Tick sources arrive as four single-cycle enable inputs, all in the block's own clock domain. Control-register code 01 selects the input that carries the 24 MHz oscillator rate. Because the current count can be written at any time, the delay to the first expiry can differ from the reload interval that follows it.

Top module: `dctimer`

## Requirements
- R1: After reset every register reads zero, and `irq` is low.
- R2: The register map is as follows. The enable register is at 0x00. The status register is at 0x04. Channel n has its control register at 0x10+0x10·n (bits 7:0 are stored, higher bits read as zero), its interval register at 0x14+0x10·n, and its current count at 0x18+0x10·n. Every other address reads zero and ignores writes.
- R3: Control bits 3:2 select which `src_en` bit paces the channel, and bits 6:4 hold the divisor minus one. A channel started with count N and field value p expires (N+1)·(p+1) active source cycles after the write that set its start bit.
- R4: A channel whose start bit (control bit 0) is clear, or whose selected `src_en` bit is low, keeps its current count unchanged.
- R5: If autoreload (control bit 1) is set, the current count loads the interval value on the expiry tick. An interval of 0xFFFFFFFF therefore wraps the count from 0 to 0xFFFFFFFF, after which it keeps counting down.
- R6: If autoreload is clear, expiry clears the start bit and the count stays at zero.
- R7: Control bit 7 selects the mode. With the bit at 1 (single), an autoreloading channel reloads its count but clears its start bit. With the bit at 0 (continuous), the channel keeps running and expires again every interval+1 ticks.
- R8: Status bit n sets on an expiry of channel n whether or not its interrupt is enabled. Writing 1 to a status bit clears it, and writing 0 leaves it unchanged.
- R9: `irq` is high exactly when some channel has both its status bit and its enable bit (enable register bit n) set.
- R10: A write to a current-count register in the same cycle as a tick of that channel stores the written value. The decrement and any expiry are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_en | input | 4 | Tick enables for the four selectable sources |
| addr | input | 8 | Register byte address |
| wr_en | input | 1 | Write strobe |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| irq | output | 1 | Combined interrupt |

## Verification
The hardest case to reach is a current-count write that lands on the very edge where the channel decrements, or where it would expire. The bench runs a channel with divisor 1 so that every cycle is a tick, then times the write from the falling edge so that it meets a known count. The all-ones wrap is reached by loading a zero count under an all-ones interval, so the wrap happens on the first tick instead of after 2^32 of them. Source gating is shown by pointing a running channel at a source that is held low, then switching that source on.

// File: rtl/dctimer.sv
module dctimer #(
  parameter int NCH = 6,
  parameter int AW  = 8,
  parameter int DW  = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [3:0]    src_en,
  input  logic [AW-1:0] addr,
  input  logic          wr_en,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          irq
);
  localparam int PW     = 3;
  localparam int CW     = 8;
  localparam int A_IEN  = 0;
  localparam int A_STA  = 4;
  localparam int BASE   = 16;
  localparam int STRIDE = 16;

  logic [NCH-1:0]         ien_q, pend_q, expire;
  logic [NCH-1:0][CW-1:0] ctrl_q;
  logic [NCH-1:0][DW-1:0] ival_q, cur_q;
  logic [NCH-1:0][PW-1:0] pc_q;

  wire wr_ien = wr_en && addr == AW'(A_IEN);
  wire wr_sta = wr_en && addr == AW'(A_STA);

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    localparam logic [AW-1:0] A_CTL = AW'(BASE + STRIDE * g);
    localparam logic [AW-1:0] A_IVL = AW'(BASE + STRIDE * g + 4);
    localparam logic [AW-1:0] A_CUR = AW'(BASE + STRIDE * g + 8);

    wire          wr_ctl = wr_en && addr == A_CTL;
    wire          wr_ivl = wr_en && addr == A_IVL;
    wire          wr_cur = wr_en && addr == A_CUR;
    wire          start  = ctrl_q[g][0];
    wire          autold = ctrl_q[g][1];
    wire [1:0]    src    = ctrl_q[g][3:2];
    wire [PW-1:0] pre    = ctrl_q[g][6:4];
    wire          single = ctrl_q[g][7];
    wire          run    = start && src_en[src];
    wire          tick   = run && pc_q[g] == pre;

    assign expire[g] = tick && cur_q[g] == '0 && !wr_cur;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pc_q[g]   <= '0;
        ctrl_q[g] <= '0;
        ival_q[g] <= '0;
        cur_q[g]  <= '0;
      end else begin
        if (!start)   pc_q[g] <= '0;
        else if (run) pc_q[g] <= tick ? '0 : pc_q[g] + 1'b1;

        if (wr_ctl) ctrl_q[g] <= wdata[CW-1:0];
        else if (expire[g] && (!autold || single)) ctrl_q[g][0] <= 1'b0;

        if (wr_ivl) ival_q[g] <= wdata;

        if (wr_cur)         cur_q[g] <= wdata;
        else if (expire[g]) cur_q[g] <= autold ? ival_q[g] : '0;
        else if (tick)      cur_q[g] <= cur_q[g] - 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ien_q  <= '0;
      pend_q <= '0;
    end else begin
      if (wr_ien) ien_q <= wdata[NCH-1:0];
      pend_q <= (pend_q & ~(wr_sta ? wdata[NCH-1:0] : '0)) | expire;
    end
  end

  assign irq = |(pend_q & ien_q);

  always_comb begin
    rdata = '0;
    if (addr == AW'(A_IEN)) rdata[NCH-1:0] = ien_q;
    if (addr == AW'(A_STA)) rdata[NCH-1:0] = pend_q;
    for (int i = 0; i < NCH; i++) begin
      if (addr == AW'(BASE + STRIDE * i))     rdata = DW'(ctrl_q[i]);
      if (addr == AW'(BASE + STRIDE * i + 4)) rdata = ival_q[i];
      if (addr == AW'(BASE + STRIDE * i + 8)) rdata = cur_q[i];
    end
  end
endmodule

// File: rtl/dctimer_chk.sv
module dctimer_chk #(
  parameter int NCH = 6,
  parameter int AW  = 8,
  parameter int DW  = 32
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [AW-1:0]          addr,
  input logic                   wr_en,
  input logic                   irq,
  input logic [NCH-1:0]         ien_q,
  input logic [NCH-1:0]         pend_q,
  input logic [NCH-1:0][7:0]    ctrl_q,
  input logic [NCH-1:0][DW-1:0] cur_q
);
  wire chk_unused = ^ctrl_q;

  assert_masked_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ien_q == '0) |-> !irq);

  assert_irq_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (pend_q != '0));

  for (genvar g = 0; g < NCH; g++) begin : g_chk
    localparam logic [AW-1:0] A_CUR = AW'(16 + 16 * g + 8);

    assert_idle_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl_q[g][0] && !(wr_en && addr == A_CUR)) |=> $stable(cur_q[g]));

    assert_pend_origin_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pend_q[g]) |-> ($past(ctrl_q[g][0]) && $past(cur_q[g]) == '0));

    assert_no_grow_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_q[g] > $past(cur_q[g])) |-> ($past(wr_en && addr == A_CUR) || $past(ctrl_q[g][1])));

    assert_stop_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(ctrl_q[g][0]) && !$past(wr_en) && !ctrl_q[g][1]) |-> cur_q[g] == '0);

    assert_keep_running_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(ctrl_q[g][0] && ctrl_q[g][1] && !ctrl_q[g][7]) && !$past(wr_en)) |-> ctrl_q[g][0]);
  end
endmodule

bind dctimer dctimer_chk #(.NCH(NCH), .AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .irq(irq),
  .ien_q(ien_q), .pend_q(pend_q), .ctrl_q(ctrl_q), .cur_q(cur_q)
);

// File: tb/sim_dctimer.sv
module sim_dctimer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  src_en = 4'b0010;
  logic [7:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  int n_cmp = 0;
  int n_bad = 0;

  dctimer u0 (.clk(clk), .rst_n(rst_n), .src_en(src_en), .addr(addr),
              .wr_en(wr_en), .wdata(wdata), .rdata(rdata), .irq(irq));

  always #5 clk = ~clk;

  // {src[1:0], prescale field[2:0], start count[7:0]}
  localparam logic [12:0] VEC [6] = '{13'h0800, 13'h0805, 13'h0B04,
                                      13'h1702, 13'h0109, 13'h1C03};

  function automatic logic [7:0] a_ctl(input int ch); return 8'(16 + 16 * ch); endfunction
  function automatic logic [7:0] a_ivl(input int ch); return 8'(20 + 16 * ch); endfunction
  function automatic logic [7:0] a_cur(input int ch); return 8'(24 + 16 * ch); endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic wait_pend(input int ch, output int cyc);
    logic [31:0] s;
    cyc = 0;
    rd(8'h04, s);
    while (!s[ch] && cyc < 1000) begin
      @(negedge clk);
      cyc++;
      rd(8'h04, s);
    end
  endtask

  initial begin
    #2000000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int cyc;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(8'h00, d); chk("R1 enable", d, 0);
    rd(8'h04, d); chk("R1 status", d, 0);
    rd(8'h10, d); chk("R1 ctrl0", d, 0);
    rd(8'h64, d); chk("R1 ival5", d, 0);
    rd(8'h68, d); chk("R1 cur5", d, 0);
    chk("R1 irq", {31'b0, irq}, 0);

    // R2 map and readback
    wr(8'h0C, 32'hDEADBEEF); rd(8'h0C, d); chk("R2 hole 0C", d, 0);
    rd(8'h1C, d); chk("R2 hole 1C", d, 0);
    wr(8'h64, 32'hA5A51234); rd(8'h64, d); chk("R2 ival5", d, 32'hA5A51234);
    wr(8'h30, 32'hFFFFFF7E); rd(8'h30, d); chk("R2 ctrl2 width", d, 32'h7E);
    wr(8'h30, 0);

    // Table: R3 timing, R6 stop without autoreload, R8 clear
    for (int v = 0; v < 6; v++) begin
      int ch = v % 6;
      int src = int'(VEC[v][12:11]);
      int pre = int'(VEC[v][10:8]);
      int n   = int'(VEC[v][7:0]);
      src_en = 4'(1 << src);
      wr(a_cur(ch), 32'(n));
      wr(a_ctl(ch), 32'(8'h81 | (pre << 4) | (src << 2)));
      wait_pend(ch, cyc);
      chk($sformatf("R3 period vec%0d", v), 32'(cyc), 32'((n + 1) * (pre + 1)));
      rd(a_ctl(ch), d); chk("R6 start cleared", {31'b0, d[0]}, 0);
      rd(a_cur(ch), d); chk("R6 held at zero", d, 0);
      wr(8'h04, 32'(1 << ch)); rd(8'h04, d); chk("R8 w1c", d, 0);
    end

    // R4 source gating and stop
    src_en = 4'b0001;
    wr(a_cur(0), 7);
    wr(a_ctl(0), 32'h85);
    repeat (20) @(negedge clk);
    rd(a_cur(0), d); chk("R4 source low holds", d, 7);
    src_en = 4'b0010;
    repeat (3) @(negedge clk);
    rd(a_cur(0), d); chk("R4 source high counts", d, 4);
    wr(a_ctl(0), 32'h84);
    repeat (5) @(negedge clk);
    rd(a_cur(0), d); chk("R4 stopped holds", d, 3);

    // R10 write priority over decrement
    wr(a_ivl(1), 100);
    wr(a_cur(1), 50);
    wr(a_ctl(1), 32'h07);
    repeat (2) @(negedge clk);
    rd(a_cur(1), d); chk("R3 divide-by-1", d, 48);
    wr(a_cur(1), 32'h200);
    rd(a_cur(1), d); chk("R10 write wins", d, 32'h200);
    @(negedge clk);
    rd(a_cur(1), d); chk("R10 resumes", d, 32'h1FF);

    // R5 all-ones wrap
    wr(a_ctl(1), 0);
    wr(a_ivl(1), 32'hFFFFFFFF);
    wr(a_cur(1), 0);
    wr(a_ctl(1), 32'h07);
    @(negedge clk);
    rd(a_cur(1), d); chk("R5 wrap", d, 32'hFFFFFFFF);
    rd(8'h04, d); chk("R8 set while disabled", d, 32'h2);
    rd(a_ctl(1), d); chk("R7 continuous runs", d, 32'h07);
    chk("R9 masked", {31'b0, irq}, 0);
    @(negedge clk);
    rd(a_cur(1), d); chk("R5 after wrap", d, 32'hFFFFFFFE);
    wr(a_ctl(1), 0);

    // R9 interrupt gating, R8 write 0 no effect
    wr(8'h00, 32'h2); chk("R9 enabled", {31'b0, irq}, 1);
    wr(8'h04, 32'h0); rd(8'h04, d); chk("R8 write 0 keeps", d, 32'h2);
    chk("R9 still high", {31'b0, irq}, 1);
    wr(8'h04, 32'h2); chk("R9 cleared", {31'b0, irq}, 0);
    wr(8'h00, 0);

    // R7 single mode with autoreload
    wr(a_ivl(3), 9);
    wr(a_cur(3), 2);
    wr(a_ctl(3), 32'h97);
    wait_pend(3, cyc);
    chk("R3 prescale 2", 32'(cyc), 6);
    rd(a_cur(3), d); chk("R7 single reloads", d, 9);
    rd(a_ctl(3), d); chk("R7 single stops", d, 32'h96);
    repeat (10) @(negedge clk);
    rd(a_cur(3), d); chk("R7 single holds", d, 9);
    wr(8'h04, 32'h8);

    // R5/R7 continuous repeat
    wr(a_ivl(4), 3);
    wr(a_cur(4), 3);
    wr(a_ctl(4), 32'h07);
    wait_pend(4, cyc);
    chk("R3 first expiry", 32'(cyc), 4);
    rd(a_cur(4), d); chk("R5 reload", d, 3);
    repeat (3) @(negedge clk);
    rd(a_cur(4), d); chk("R7 counts down", d, 0);
    @(negedge clk);
    rd(a_cur(4), d); chk("R5 second reload", d, 3);
    rd(a_ctl(4), d); chk("R7 still started", d, 32'h07);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule